// File: doc/BRIEF.md
# Four-Channel Output Compare Unit

This block drives four output pins from one shared 16-bit timer count supplied from outside. Every channel holds its own 16-bit compare value and a 2-bit action mode. When the count moves onto a channel's compare value while the global enable is on, the channel's pin is set, cleared or toggled as its mode selects. Mode 0 instead forces the pin to the channel's initial-value bit and holds it there, ignoring matches. After the force is lifted, the pin keeps the forced level until a later match acts on it.

Software reaches the block through a byte-wide write port and a combinational read port. A compare value is loaded low byte first. The low byte sits in a staging register and only the high-byte write commits the whole 16-bit value, so a half-written value can never cause a match. A match counts once per count value: a count that stalls on the compare value acts only on the cycle it arrives there.

Top module: `oc_quad_compare`

## Requirements
- R1: After reset all four pins are 0 and every readable register (compare bytes, channel config, control) reads 0.
- R2: While the enable bit (bit 0 of the control byte at address 12) is 0, no compare match changes any pin that is not in force mode.
- R3: A channel in mode 01 (set) drives its pin to 1 on the clock edge after the count arrives at its compare value.
- R4: A channel in mode 10 (clear) drives its pin to 0 on the clock edge after the count arrives at its compare value.
- R5: A channel in mode 11 (toggle) inverts its pin on the clock edge after the count arrives at its compare value.
- R6: A channel in mode 00 (force) drives its pin to its initial-value bit on every clock edge, whatever the count, compare value or enable. Channel c's config byte sits at address 8+c: bits 1:0 the mode, bit 2 the initial-value bit.
- R7: When a channel's mode is not 00 and no match occurs, its pin keeps its level; in particular a pin released from force keeps the forced level until a later match.
- R8: A match counts only on a cycle when the count differs from its value in the previous cycle; a count held on the compare value acts once.
- R9: Channel c's compare low byte is written at address 2c and is held in staging without changing the compare value; writing the high byte at address 2c+1 commits {high, staged low} as the new compare value. Reads of addresses 2c and 2c+1 return the committed low and high bytes.
- R10: Each channel acts only on its own compare value and mode; channels sharing a compare value act together, each with its own action.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_i | input | 16 | Shared timer count |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 4 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| pin_o | output | 4 | Output pin levels, bit c for channel c |

## Verification
The assertions check on every cycle the per-mode effect of a match on the pin, the force hold, the hold in absence of a match, the absence of matches while disabled, the single firing on a held count, and that a staged low byte never alters a committed compare value. What only the bench's scenarios show is the end-to-end chain from byte writes to pin levels: that the staged and committed bytes combine in the right order, that a release from force keeps the forced level until a later match, and that the right channel reacts to the right address and compare value.

// File: rtl/oc_pkg.sv
package oc_pkg;

  typedef enum logic [1:0] {
    OC_FORCE  = 2'b00,
    OC_SET    = 2'b01,
    OC_CLEAR  = 2'b10,
    OC_TOGGLE = 2'b11
  } oc_mode_e;

  // Next pin level for a channel given its mode, current level, init bit and match.
  function automatic logic oc_next_pin(oc_mode_e mode, logic cur, logic init, logic hit);
    logic nxt;
    nxt = cur;
    if (mode == OC_FORCE) begin
      nxt = init;
    end else if (hit) begin
      case (mode)
        OC_SET:    nxt = 1'b1;
        OC_CLEAR:  nxt = 1'b0;
        default:   nxt = ~cur;
      endcase
    end
    return nxt;
  endfunction

  // A match: enabled, count moved this cycle, and count now equals compare.
  function automatic logic oc_is_hit(logic en, logic moved, logic [15:0] cnt, logic [15:0] cmp);
    return en && moved && (cnt == cmp);
  endfunction

endpackage

// File: rtl/oc_regfile.sv
module oc_regfile
  import oc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            wr_addr_i,
  input  logic [7:0]                   wr_data_i,
  input  logic [ADDR_W-1:0]            rd_addr_i,
  output logic [7:0]                   rd_data_o,
  output logic [NUM_CH-1:0][CNT_W-1:0] cmp_o,
  output logic [NUM_CH-1:0][1:0]       mode_o,
  output logic [NUM_CH-1:0]            init_o,
  output logic                         en_o
);

  localparam int BYTES     = CNT_W / 8;
  localparam int STG_W     = CNT_W - 8;
  localparam int CFG_BASE  = NUM_CH * BYTES;
  localparam int CTRL_ADDR = CFG_BASE + NUM_CH;

  logic [NUM_CH-1:0][CNT_W-1:0] cmp_q;
  logic [NUM_CH-1:0][STG_W-1:0] stage_q;
  logic [NUM_CH-1:0][1:0]       mode_q;
  logic [NUM_CH-1:0]            init_q;
  logic                         en_q;
  logic [NUM_CH-1:0]            low_wr;   // staging write seen per channel
  logic [NUM_CH-1:0]            high_wr;  // commit write seen per channel

  wire unused_wdata = ^wr_data_i[7:3];

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      low_wr[c]  = 1'b0;
      high_wr[c] = wr_en_i && (wr_addr_i == ADDR_W'(c*BYTES + BYTES - 1));
      for (int b = 0; b < BYTES-1; b++) begin
        if (wr_en_i && (wr_addr_i == ADDR_W'(c*BYTES + b))) low_wr[c] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q   <= '0;
      stage_q <= '0;
      mode_q  <= '0;
      init_q  <= '0;
      en_q    <= 1'b0;
    end else if (wr_en_i) begin
      for (int c = 0; c < NUM_CH; c++) begin
        for (int b = 0; b < BYTES-1; b++) begin
          if (wr_addr_i == ADDR_W'(c*BYTES + b)) stage_q[c][b*8 +: 8] <= wr_data_i;
        end
        if (high_wr[c]) cmp_q[c] <= {wr_data_i, stage_q[c]};
        if (wr_addr_i == ADDR_W'(CFG_BASE + c)) begin
          mode_q[c] <= wr_data_i[1:0];
          init_q[c] <= wr_data_i[2];
        end
      end
      if (wr_addr_i == ADDR_W'(CTRL_ADDR)) en_q <= wr_data_i[0];
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int b = 0; b < BYTES; b++) begin
        if (rd_addr_i == ADDR_W'(c*BYTES + b)) rd_data_o = cmp_q[c][b*8 +: 8];
      end
      if (rd_addr_i == ADDR_W'(CFG_BASE + c)) rd_data_o = {5'b0, init_q[c], mode_q[c]};
    end
    if (rd_addr_i == ADDR_W'(CTRL_ADDR)) rd_data_o = {7'b0, en_q};
  end

  assign cmp_o  = cmp_q;
  assign mode_o = mode_q;
  assign init_o = init_q;
  assign en_o   = en_q;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      // R9: a staging write leaves the committed compare value untouched
      a_r9_low_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (low_wr[c] && !high_wr[c]) |=> $stable(cmp_o[c]));
      // R9: a commit write loads the high byte as written
      a_r9_high_commit: assert property (@(posedge clk) disable iff (!rst_n)
        high_wr[c] |=> (cmp_o[c][CNT_W-1 -: 8] == $past(wr_data_i)));
    end
  endgenerate

endmodule

// File: rtl/oc_match.sv
module oc_match
  import oc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [CNT_W-1:0]             count_i,
  input  logic                         en_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cmp_i,
  output logic                         moved_o,
  output logic [NUM_CH-1:0]            match_o
);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_i;
  end

  assign moved_o = (count_i != count_q);

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign match_o[c] = oc_is_hit(en_i, moved_o, count_i, cmp_i[c]);

      // R8: a count held on the compare value does not fire twice
      a_r8_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
        match_o[c] |=> (!match_o[c] || !$stable(count_i)));
    end
  endgenerate

  // R2: no match is reported while the enable is low
  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> (match_o == '0));

endmodule

// File: rtl/oc_pin.sv
module oc_pin
  import oc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       init_i,
  input  logic       match_i,
  output logic       pin_o
);

  oc_mode_e mode;
  logic     pin_q;

  assign mode = oc_mode_e'(mode_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= oc_next_pin(mode, pin_q, init_i, match_i);
  end

  assign pin_o = pin_q;

  // R6: force mode drives the init bit regardless of matches
  a_r6_force_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OC_FORCE) |=> (pin_o == $past(init_i)));
  // R7: without a match, a non-forced pin keeps its level
  a_r7_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != OC_FORCE && !match_i) |=> $stable(pin_o));
  // R3: set action
  a_r3_set_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OC_SET && match_i) |=> pin_o);
  // R4: clear action
  a_r4_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OC_CLEAR && match_i) |=> !pin_o);
  // R5: toggle action
  a_r5_toggle_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OC_TOGGLE && match_i) |=> (pin_o != $past(pin_o)));

endmodule

// File: rtl/oc_quad_compare.sv
module oc_quad_compare
  import oc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic [NUM_CH-1:0] pin_o
);

  logic [NUM_CH-1:0][CNT_W-1:0] cmp;
  logic [NUM_CH-1:0][1:0]       mode;
  logic [NUM_CH-1:0]            init_bit;
  logic                         enable;
  logic [NUM_CH-1:0]            match;
  logic                         count_moved;

  oc_regfile #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .cmp_o     (cmp),
    .mode_o    (mode),
    .init_o    (init_bit),
    .en_o      (enable)
  );

  oc_match #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .count_i (count_i),
    .en_i    (enable),
    .cmp_i   (cmp),
    .moved_o (count_moved),
    .match_o (match)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_pin
      oc_pin u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode[c]),
        .init_i  (init_bit[c]),
        .match_i (match[c]),
        .pin_o   (pin_o[c])
      );
    end
  endgenerate

  // R8: any reported match comes with a count that moved this cycle
  a_r8_match_needs_move: assert property (@(posedge clk) disable iff (!rst_n)
    (match != '0) |-> count_moved);

endmodule

// File: tb/oc_quad_compare_bench.sv
module oc_quad_compare_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] count;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [3:0]  rd_addr;
  logic [7:0]  rd_data;
  logic [3:0]  pin;

  always #4 clk = ~clk;  // 125 MHz

  oc_quad_compare u_oc_quad_compare (
    .clk(clk), .rst_n(rst_n), .count_i(count),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .pin_o(pin)
  );

  typedef struct { logic [3:0] exp; string req; } item_t;
  item_t q[$];

  // Reference state, kept from the requirements
  logic [15:0] m_cmp [4];
  logic [7:0]  m_stg [4];
  logic [1:0]  m_mode[4];
  logic [3:0]  m_init;
  logic        m_en;
  logic [3:0]  m_pin;
  logic [15:0] m_prev;
  logic [15:0] cur_cnt;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic cyc(input logic we, input logic [3:0] a, input logic [7:0] d,
                     input logic [15:0] c, input string req);
    logic [3:0] nxt;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; count = c; cur_cnt = c;
    nxt = m_pin;
    for (int i = 0; i < 4; i++) begin
      if (m_mode[i] == 2'b00) nxt[i] = m_init[i];
      else if (m_en && c != m_prev && c == m_cmp[i]) begin
        if (m_mode[i] == 2'b01)      nxt[i] = 1'b1;
        else if (m_mode[i] == 2'b10) nxt[i] = 1'b0;
        else                         nxt[i] = ~m_pin[i];
      end
    end
    m_pin = nxt; m_prev = c;
    if (we) begin
      if (a < 4'd8) begin
        if (a[0]) m_cmp[a[2:1]] = {d, m_stg[a[2:1]]};
        else      m_stg[a[2:1]] = d;
      end else if (a < 4'd12) begin
        m_mode[a[1:0]] = d[1:0];
        m_init[a[1:0]] = d[2];
      end else if (a == 4'd12) m_en = d[0];
    end
    q.push_back('{nxt, req});
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input string req);
    cyc(1'b1, a, d, cur_cnt, req);
  endtask

  task automatic idle(input logic [15:0] c, input string req);
    cyc(1'b0, 4'd0, 8'd0, c, req);
  endtask

  task automatic rdchk(input logic [3:0] a, input logic [7:0] e, input string req);
    rd_addr = a;
    #1;
    n_cmp++;
    if (rd_data !== e) begin
      n_bad++;
      $display("FAIL %s: read addr %0d got %h expected %h", req, a, rd_data, e);
    end
  endtask

  // Monitor: pop one expected pin vector after each edge
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        n_cmp++;
        if (pin !== it.exp) begin
          n_bad++;
          $display("FAIL %s: pins %b expected %b", it.req, pin, it.exp);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; count = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    cur_cnt = '0;
    for (int i = 0; i < 4; i++) begin
      m_cmp[i] = '0; m_stg[i] = '0; m_mode[i] = '0;
    end
    m_init = '0; m_en = 1'b0; m_pin = '0; m_prev = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state at the ports
    n_cmp++;
    if (pin !== 4'b0000) begin
      n_bad++; $display("FAIL R1: pins %b expected 0000", pin);
    end
    for (int a = 0; a < 13; a++) rdchk(4'(a), 8'h00, "R1");

    // R6: force ch1, ch2 to init 1 (config byte: bit2 init, bits1:0 mode)
    wr(4'd9,  8'h04, "R6");
    wr(4'd10, 8'h04, "R6");
    idle(16'h0, "R6");
    rdchk(4'd9, 8'h04, "R6");

    // R9: staged low byte does not show until high byte is written
    wr(4'd0, 8'h10, "R9");
    idle(16'h0, "R9");
    rdchk(4'd0, 8'h00, "R9");
    rdchk(4'd1, 8'h00, "R9");
    wr(4'd1, 8'h00, "R9");
    idle(16'h0, "R9");
    rdchk(4'd0, 8'h10, "R9");
    wr(4'd2, 8'h20, "R9"); wr(4'd3, 8'h00, "R9");
    wr(4'd4, 8'h30, "R9"); wr(4'd5, 8'h00, "R9");
    wr(4'd6, 8'h30, "R9"); wr(4'd7, 8'h00, "R9");

    // R7: release ch1/ch2 into clear/toggle; levels held. ch0 set, ch3 forced 0
    wr(4'd8,  8'h01, "R7");
    wr(4'd9,  8'h06, "R7");
    wr(4'd10, 8'h07, "R7");
    idle(16'h0, "R7");

    // R2: disabled sweep across all compare values
    for (int c = 1; c <= 16'h35; c++) idle(16'(c), "R2");
    idle(16'h0, "R2");

    // Enable (control byte bit 0)
    wr(4'd12, 8'h01, "R2");
    // R3 R4 R5 R6 R10: sweep through matches
    for (int c = 1; c <= 16'h30; c++) idle(16'(c), "R3 R4 R5 R6 R10");
    // R8: stalled count on compare value
    repeat (5) idle(16'h30, "R8");
    idle(16'h31, "R8");
    idle(16'h30, "R5 R8");

    // R7: release ch3 (was forced 0) into toggle; keeps 0 until a match
    wr(4'd11, 8'h07, "R7");
    idle(16'h2F, "R7");
    idle(16'h30, "R5 R7 R10");
    // R6: force ch3 to 1 while its compare value keeps matching
    wr(4'd11, 8'h04, "R6");
    idle(16'h31, "R6");
    idle(16'h30, "R6");
    idle(16'h31, "R6");
    idle(16'h30, "R6");

    // R9: half-written ch2 compare (low 0x40) must not match at 0x40
    wr(4'd4, 8'h40, "R9");
    idle(16'h40, "R9");
    idle(16'h30, "R9");
    wr(4'd5, 8'h00, "R9");
    idle(16'h41, "R9");
    idle(16'h40, "R9 R5");
    idle(16'h30, "R9");

    // R4 R3: drive ch0 low by force then release and set again
    wr(4'd8, 8'h00, "R6");
    wr(4'd8, 8'h01, "R7");
    idle(16'h11, "R7");
    idle(16'h10, "R3");
    wr(4'd9, 8'h04, "R6");
    wr(4'd9, 8'h06, "R7");
    idle(16'h20, "R4");

    // R2: disable again, sweep
    wr(4'd12, 8'h00, "R2");
    for (int c = 16'h0F; c <= 16'h42; c++) idle(16'(c), "R2");

    repeat (3) idle(cur_cnt, "R7");
    @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule